// File: doc/BRIEF.md
# Two-Stage Pipelined Multiply-Accumulate Unit

This unit runs multiply-accumulate operations across two execute stages. Each issued operation brings two multiplicand words and the index of one entry in a small accumulator file. In the first stage (E) the lower 24 bits of each multiplicand are multiplied without sign, and the product is registered. In the second stage (E+1) the product is added to the chosen accumulator. The sum is registered onto the result port and written back into the accumulator file on the following edge.

The `SCHED` parameter selects when the accumulator is read. With the late schedule, the accumulator is read in E+1. A forwarding path from the result register lets an operation that depends on the one just before it issue on the very next cycle. With the early schedule, the accumulator is read in E together with the multiplicands. A dependent operation that follows its producer on the next cycle therefore holds for one bubble cycle, and the unit signals this on `stall`. Fetch and decode sit outside the block. The issuer keeps its inputs steady while `stall` is high.

Top module: `mac2_pipe`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `stall` and `res_valid` are low. Every accumulator entry holds zero after reset.
- R2: The product uses only bits [23:0] of `iss_mcand` and `iss_mplier`, taken as unsigned. Bits [31:24] have no effect on any result.
- R3: A result equals the prior value of the named accumulator plus the product, modulo 2^48. It becomes the new value of that accumulator.
- R4: An operation is accepted on a rising edge when `iss_valid` is high and `stall` is low. Its result shows on `res_data`, with its index on `res_idx` and `res_valid` high, after the second rising edge that follows.
- R5: With the late schedule, back-to-back operations on the same accumulator never raise `stall`, and each one sees the sum of the one before it.
- R6: With the early schedule, an operation that names the same accumulator as the operation accepted on the previous edge raises `stall` for exactly one cycle and is not accepted in that cycle. It is accepted on the next edge and sees the earlier sum.
- R7: Operations on different accumulators issue on consecutive cycles under either schedule without raising `stall`.
- R8: `stall` is high only when `iss_valid` is high and an operation was accepted on the previous edge. When one idle cycle separates two operations on the same accumulator, no stall occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An operation is offered |
| iss_mcand | input | 32 | First multiplicand word (bits [23:0] used) |
| iss_mplier | input | 32 | Second multiplicand word (bits [23:0] used) |
| iss_acc | input | 3 | Accumulator index |
| stall | output | 1 | Bubble inserted; the offered operation is not taken this cycle |
| res_valid | output | 1 | A result is present |
| res_idx | output | 3 | Accumulator index of the result |
| res_data | output | 48 | New accumulator value |

## Verification
The bench builds two copies of the default configuration, with 8 accumulators of 48 bits and 24-bit multiplicands. One copy uses the late schedule and the other the early schedule, and both receive the same stimulus. Every ordered pair of accumulator indices is issued back-to-back on both copies. This covers every dependent and independent adjacency, so the presence or absence of a bubble can be compared between the schedules. Chains of maximum-value operands with the upper bits set reach the 2^48 wrap and show that the upper bits are ignored.

// File: rtl/mac2_pkg.sv
package mac2_pkg;
  typedef enum logic {
    SCHED_EARLY = 1'b0,
    SCHED_LATE  = 1'b1
  } sched_e;
endpackage

// File: rtl/mac2_mul_stage.sv
module mac2_mul_stage #(
  parameter int OPW  = 32,
  parameter int MULW = 24,
  parameter int ACCW = 48,
  parameter int IDXW = 3,
  localparam int PW  = 2 * MULW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [OPW-1:0]  in_a,
  input  logic [OPW-1:0]  in_b,
  input  logic [IDXW-1:0] in_idx,
  input  logic [ACCW-1:0] in_acc,
  output logic            out_valid,
  output logic [IDXW-1:0] out_idx,
  output logic [PW-1:0]   out_prod,
  output logic [ACCW-1:0] out_acc
);
  logic [MULW-1:0] a_lo, b_lo;
  logic            unused_hi;

  assign a_lo      = in_a[MULW-1:0];
  assign b_lo      = in_b[MULW-1:0];
  assign unused_hi = ^{in_a[OPW-1:MULW], in_b[OPW-1:MULW]};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_prod  <= '0;
      out_acc   <= '0;
    end else begin
      out_valid <= in_valid;
      out_idx   <= in_idx;
      out_prod  <= PW'(a_lo) * PW'(b_lo);
      out_acc   <= in_acc;
    end
  end
endmodule

// File: rtl/mac2_acc_file.sv
module mac2_acc_file #(
  parameter int NACC = 8,
  parameter int ACCW = 48,
  localparam int IDXW = $clog2(NACC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [ACCW-1:0] wr_data,
  input  logic [IDXW-1:0] rd_idx,
  output logic [ACCW-1:0] rd_data
);
  logic [ACCW-1:0] acc_mem [NACC];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NACC; k++) acc_mem[k] <= '0;
    end else if (wr_en) begin
      acc_mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = acc_mem[rd_idx];
endmodule

// File: rtl/mac2_sum_stage.sv
module mac2_sum_stage #(
  parameter int ACCW = 48,
  parameter int PW   = 48,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [IDXW-1:0] in_idx,
  input  logic [PW-1:0]   in_prod,
  input  logic [ACCW-1:0] in_acc,
  output logic            out_valid,
  output logic [IDXW-1:0] out_idx,
  output logic [ACCW-1:0] out_data
);
  logic [ACCW-1:0] sum;

  assign sum = in_acc + ACCW'(in_prod);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_idx   <= in_idx;
      out_data  <= sum;
    end
  end
endmodule

// File: rtl/mac2_pipe.sv
module mac2_pipe
  import mac2_pkg::*;
#(
  parameter int     OPW   = 32,
  parameter int     MULW  = 24,
  parameter int     ACCW  = 48,
  parameter int     NACC  = 8,
  parameter sched_e SCHED = SCHED_LATE,
  localparam int    IDXW  = $clog2(NACC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            iss_valid,
  input  logic [OPW-1:0]  iss_mcand,
  input  logic [OPW-1:0]  iss_mplier,
  input  logic [IDXW-1:0] iss_acc,
  output logic            stall,
  output logic            res_valid,
  output logic [IDXW-1:0] res_idx,
  output logic [ACCW-1:0] res_data
);
  localparam int PW      = 2 * MULW;
  localparam bit IS_LATE = (SCHED == SCHED_LATE);

  logic            accept;
  logic            e1_valid;
  logic [IDXW-1:0] e1_idx;
  logic [PW-1:0]   e1_prod;
  logic [ACCW-1:0] e1_acc;
  logic [IDXW-1:0] rf_raddr;
  logic [ACCW-1:0] rf_rdata;
  logic            fwd_hit;
  logic [ACCW-1:0] acc_now;
  logic [ACCW-1:0] acc_opnd;

  // A bubble is only needed when the accumulator is read in E and the
  // producer is still in E+1.
  assign stall  = !IS_LATE && iss_valid && e1_valid && (iss_acc == e1_idx);
  assign accept = iss_valid && !stall;

  // One read port; the schedule decides which stage addresses it.
  assign rf_raddr = IS_LATE ? e1_idx : iss_acc;
  assign fwd_hit  = res_valid && (res_idx == rf_raddr);
  assign acc_now  = fwd_hit ? res_data : rf_rdata;
  assign acc_opnd = IS_LATE ? acc_now : e1_acc;

  mac2_mul_stage #(.OPW(OPW), .MULW(MULW), .ACCW(ACCW), .IDXW(IDXW)) u_mul (
    .clk(clk), .rst(rst),
    .in_valid(accept), .in_a(iss_mcand), .in_b(iss_mplier),
    .in_idx(iss_acc), .in_acc(acc_now),
    .out_valid(e1_valid), .out_idx(e1_idx), .out_prod(e1_prod), .out_acc(e1_acc)
  );

  mac2_acc_file #(.NACC(NACC), .ACCW(ACCW)) u_file (
    .clk(clk), .rst(rst),
    .wr_en(res_valid), .wr_idx(res_idx), .wr_data(res_data),
    .rd_idx(rf_raddr), .rd_data(rf_rdata)
  );

  mac2_sum_stage #(.ACCW(ACCW), .PW(PW), .IDXW(IDXW)) u_sum (
    .clk(clk), .rst(rst),
    .in_valid(e1_valid), .in_idx(e1_idx), .in_prod(e1_prod), .in_acc(acc_opnd),
    .out_valid(res_valid), .out_idx(res_idx), .out_data(res_data)
  );

  AST_RES_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(iss_valid && !stall, 2)); // R4
  AST_RES_INDEX: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_idx == $past(iss_acc, 2))); // R4
  AST_SINGLE_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall); // R6
  AST_STALL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    stall |-> (iss_valid && $past(iss_valid && !stall))); // R8
  AST_LATE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && $past(iss_valid && !stall) && (iss_acc == $past(iss_acc)) && IS_LATE) |-> !stall); // R5
endmodule

// File: tb/test_mac2_pipe.sv
module test_mac2_pipe;
  import mac2_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        v   [2];
  logic [31:0] ma  [2];
  logic [31:0] mb  [2];
  logic [2:0]  ix  [2];
  logic        st  [2];
  logic        rv  [2];
  logic [2:0]  ri  [2];
  logic [47:0] rd  [2];

  int checks = 0;
  int bad    = 0;
  int cyc    = 0;
  bit done   = 0;

  logic [47:0] model [2][8];
  logic [47:0] q_data [2][1024];
  logic [2:0]  q_idx  [2][1024];
  int          q_cyc  [2][1024];
  int head [2];
  int tail [2];
  int last_cyc [2];
  int last_idx [2];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mac2_pipe #(.SCHED(SCHED_LATE)) i_mac2_pipe (
    .clk(clk), .rst(rst), .iss_valid(v[0]), .iss_mcand(ma[0]), .iss_mplier(mb[0]),
    .iss_acc(ix[0]), .stall(st[0]), .res_valid(rv[0]), .res_idx(ri[0]), .res_data(rd[0]));

  mac2_pipe #(.SCHED(SCHED_EARLY)) i_mac2_pipe_early (
    .clk(clk), .rst(rst), .iss_valid(v[1]), .iss_mcand(ma[1]), .iss_mplier(mb[1]),
    .iss_acc(ix[1]), .stall(st[1]), .res_valid(rv[1]), .res_idx(ri[1]), .res_data(rd[1]));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic issue(input int u, input logic [31:0] a, input logic [31:0] b, input int idx, input string req);
    int c;
    int stalls;
    logic exp_st;
    logic [47:0] p;
    v[u] = 1'b1; ma[u] = a; mb[u] = b; ix[u] = idx[2:0];
    c = cyc;
    exp_st = (u == 1) && (last_cyc[u] == c - 1) && (last_idx[u] == idx);
    stalls = 0;
    #1;
    check(st[u] === exp_st, req, 64'(st[u]), 64'(exp_st));
    while (st[u] === 1'b1 && stalls < 4) begin
      stalls++;
      @(posedge clk); @(negedge clk); #1;
    end
    // R6: a bubble lasts exactly one cycle
    check(stalls == int'(exp_st), "R6 bubble length", 64'(stalls), 64'(exp_st));
    c = cyc;
    @(posedge clk);
    p = {24'h0, a[23:0]} * {24'h0, b[23:0]};
    model[u][idx] = model[u][idx] + p;
    q_data[u][tail[u]] = model[u][idx];
    q_idx[u][tail[u]]  = idx[2:0];
    q_cyc[u][tail[u]]  = c;
    tail[u]++;
    last_cyc[u] = c;
    last_idx[u] = idx;
    @(negedge clk);
  endtask

  task automatic idle(input int u, input int n);
    for (int k = 0; k < n; k++) begin
      v[u] = 1'b0;
      #1;
      check(st[u] === 1'b0, "R8 no stall when idle", 64'(st[u]), 64'd0);
      @(posedge clk); @(negedge clk);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int u = 0; u < 2; u++) begin
        if (rv[u] === 1'b1) begin
          if (head[u] == tail[u]) begin
            check(1'b0, "R4 unexpected result", 64'(ri[u]), 64'd0);
          end else begin
            check(rd[u] === q_data[u][head[u]], "R3 result value", 64'(rd[u]), 64'(q_data[u][head[u]]));
            check(ri[u] === q_idx[u][head[u]], "R4 result index", 64'(ri[u]), 64'(q_idx[u][head[u]]));
            check(cyc == q_cyc[u][head[u]] + 2, "R4 latency", 64'(cyc), 64'(q_cyc[u][head[u]] + 2));
            head[u]++;
          end
        end
      end
    end
  end

  initial begin
    for (int u = 0; u < 2; u++) begin
      v[u] = 1'b0; ma[u] = '0; mb[u] = '0; ix[u] = '0;
      head[u] = 0; tail[u] = 0; last_cyc[u] = -10; last_idx[u] = -1;
      for (int k = 0; k < 8; k++) model[u][k] = '0;
    end
    repeat (4) @(negedge clk);
    for (int u = 0; u < 2; u++) begin
      check(st[u] === 1'b0, "R1 stall in reset", 64'(st[u]), 64'd0);
      check(rv[u] === 1'b0, "R1 res_valid in reset", 64'(rv[u]), 64'd0);
    end
    rst = 1'b0;
    @(negedge clk);
    for (int u = 0; u < 2; u++)
      check(rv[u] === 1'b0, "R1 res_valid after reset", 64'(rv[u]), 64'd0);

    for (int u = 0; u < 2; u++) begin
      // R1 R7: first touch of each entry starts at zero; distinct indices back-to-back
      for (int i = 0; i < 8; i++)
        issue(u, 32'hA500_0000 | 32'(i * 37 + 1), 32'h3C00_0000 | 32'(i * 91 + 5), i, "R7 independent issue");
      idle(u, 3);
      // R5 R6 R7: every ordered pair of indices back-to-back
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          issue(u, {8'h5A, 24'(i * 32'h13579 + j * 32'h2468 + 1)}, {8'hC3, 24'(j * 32'h1F1F + 7)}, i, "R5/R6 pair first");
          issue(u, {8'h96, 24'(j * 32'h0ABCD + 3)}, {8'h11, 24'(i * 32'h3333 + 9)}, j, "R5/R6 pair second");
          idle(u, 1);
        end
      end
      // R2 R3: maximum operands with junk upper bits wrap the 48-bit accumulator
      for (int k = 0; k < 6; k++)
        issue(u, 32'hFFFF_FFFF, 32'h80FF_FFFF, 5, "R3 wrap chain");
      idle(u, 1);
      // R2: only the upper bits differ between these two
      issue(u, 32'h0000_0003, 32'h0000_0005, 2, "R2 low bits");
      issue(u, 32'hFF00_0003, 32'h7700_0005, 6, "R2 high bits ignored");
      // R8: one idle cycle between same-index operations, no bubble
      idle(u, 1);
      issue(u, 32'h0012_3456, 32'h0065_4321, 6, "R8 gap no stall");
      idle(u, 4);
      check(head[u] == tail[u], "R4 all results seen", 64'(head[u]), 64'(tail[u]));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      check(1'b0, "watchdog", 64'(cyc), 64'd0);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule